// File: doc/BRIEF.md
# Serial Flash Status and Write-Protect Unit

This block keeps the status byte of a 2 MB serial NOR flash and decides whether a program or erase request may touch a given address. It takes decoded command strobes from the command decoder: write enable, write disable, status write, program/erase start and internal operation done. It also takes the byte offered for a status write, the active-low write-protect pin and the 21-bit target address. It returns the status byte that a status read shifts out.

Three level bits and a direction bit select the protected part of the array. The region is a power-of-two run of 64 KB blocks, anchored at the top or the bottom of the array. A lock bit, together with the write-protect pin held low, freezes the protection settings against status writes. The volatile busy and write-latch bits sequence each accepted operation. The serial shifter, the array and non-volatile timing live outside this unit. Reset loads the factory defaults.

Top module: `flash_status_guard`

## Requirements
- R1: After reset the status byte reads 8'h00, and every address may be programmed once the write latch is set.
- R2: The status byte is {lock, 0, dir, level[2:0], latch, busy}. Bit 0 is busy, bit 1 is the write latch, bits 4:2 are the protect level, bit 5 selects the bottom (1) or top (0) of the array, bit 6 always reads 0 and bit 7 is the lock bit.
- R3: While busy is 0, a write-enable strobe sets the latch and a write-disable strobe clears it.
- R4: A status write is accepted only when the latch is 1 and busy is 0. Acceptance sets busy and loads bits 7 and 5:2 from the data byte. Data bits 6, 1 and 0 have no effect. A status write with the latch at 0 changes nothing.
- R5: When the lock bit is 1 and the write-protect pin is low, an accepted status write leaves bits 7 and 5:2 unchanged but still sets busy. With the pin high the write takes effect.
- R6: An operation-done strobe while busy clears both busy and the latch.
- R7: While busy, every strobe except operation-done is ignored.
- R8: Protect level 000 protects no address, whatever the direction bit holds.
- R9: With direction 0, levels 001 to 101 protect the top 64 KB, 128 KB, 256 KB, 512 KB and 1 MB, each ending at 1FFFFFh.
- R10: With direction 1, the same levels protect the same sizes starting at address 000000h.
- R11: Levels 110 and 111 protect the same half of the array as 101.
- R12: The program-allowed output is 1 exactly when the latch is 1, busy is 0 and the address is unprotected. A program/erase strobe under those conditions sets busy.
- R13: A program/erase strobe at a protected address, with the latch set and busy clear, leaves busy at 0 and clears the latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wren | input | 1 | Write-enable strobe |
| cmd_wrdi | input | 1 | Write-disable strobe |
| cmd_wrsr | input | 1 | Status-write strobe |
| cmd_pe | input | 1 | Program/erase start strobe |
| op_done | input | 1 | Internal operation finished |
| sr_wdata | input | 8 | Byte offered by a status write |
| wp_n | input | 1 | Write-protect pin, active low |
| addr | input | 21 | Target byte address of a program/erase |
| status | output | 8 | Readable status byte |
| pe_allowed | output | 1 | Program/erase at addr would be accepted |

## Verification
Every strobe changes the status byte at the first rising edge after it is driven, so each result is due one cycle after its stimulus. The bench drives a stimulus at a falling edge and samples the status 1 ns after the next rising edge. The program-allowed flag is combinational on the current state and address. It is sampled 1 ns after the falling edge that drives the address, before the edge that may change the state. Each expected item pairs both values, so a misplaced register on either path shows up as a mismatch in the cycle it belongs to.

// File: rtl/flash_status_guard.sv
module flash_status_guard #(
  parameter int ADDR_W  = 21,
  parameter int BLOCK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic              cmd_pe,
  input  logic              op_done,
  input  logic [7:0]        sr_wdata,
  input  logic              wp_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        status,
  output logic              pe_allowed
);
  localparam int IDX_W = ADDR_W - BLOCK_W;
  localparam logic [IDX_W:0] BLK_COUNT = (IDX_W+1)'(1) << IDX_W;
  localparam logic [IDX_W:0] ONE       = (IDX_W+1)'(1);

  logic       busy, wel, dir, lock;
  logic [2:0] lvl;

  wire locked = lock & ~wp_n;

  logic [2:0]     lvl_eff;
  logic [IDX_W:0] span, blk;
  logic           in_prot;

  assign lvl_eff = (lvl > 3'd5) ? 3'd5 : lvl;
  assign span    = ONE << (lvl_eff - 3'd1);
  assign blk     = {1'b0, addr[ADDR_W-1:BLOCK_W]};
  assign in_prot = (lvl_eff != 3'd0) &&
                   (dir ? (blk < span) : (blk >= BLK_COUNT - span));

  assign pe_allowed = wel & ~busy & ~in_prot;
  assign status     = {lock, 1'b0, dir, lvl, wel, busy};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      wel  <= 1'b0;
      dir  <= 1'b0;
      lock <= 1'b0;
      lvl  <= 3'd0;
    end else if (busy) begin
      if (op_done) begin
        busy <= 1'b0;
        wel  <= 1'b0;
      end
    end else if (cmd_wren) begin
      wel <= 1'b1;
    end else if (cmd_wrdi) begin
      wel <= 1'b0;
    end else if (cmd_wrsr && wel) begin
      busy <= 1'b1;
      if (!locked) begin
        lock <= sr_wdata[7];
        dir  <= sr_wdata[5];
        lvl  <= sr_wdata[4:2];
      end
    end else if (cmd_pe && wel) begin
      if (in_prot) wel  <= 1'b0;
      else         busy <= 1'b1;
    end
  end

  wire quiet_en = !busy && wel && !cmd_wren && !cmd_wrdi;

  a_r4_wrsr_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_en && cmd_wrsr) |=> status[0]);

  a_r5_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_en && cmd_wrsr && status[7] && !wp_n) |=> $stable({status[7], status[5:2]}));

  a_r6_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && op_done) |=> (status[1:0] == 2'b00));

  a_r7_busy_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && !op_done) |=> (status[0] && $stable(status[7:1])));

  a_r12_pe_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_en && !cmd_wrsr && cmd_pe && pe_allowed) |=> status[0]);

  a_r13_pe_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_en && !cmd_wrsr && cmd_pe && !pe_allowed) |=> (status[1:0] == 2'b00));

  a_r2_reserved_low: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] || !status[0]) |-> !status[6]);
endmodule

// File: tb/flash_status_guard_tb.sv
`timescale 1ns/100ps
module flash_status_guard_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_pe = 0, op_done = 0;
  logic [7:0]  sr_wdata = 8'h00;
  logic        wp_n = 1'b1;
  logic [20:0] addr = '0;
  logic [7:0]  status;
  logic        pe_allowed;

  always #2.5 clk = ~clk;

  flash_status_guard u_dut (
    .clk, .rst_n, .cmd_wren, .cmd_wrdi, .cmd_wrsr, .cmd_pe, .op_done,
    .sr_wdata, .wp_n, .addr, .status, .pe_allowed
  );

  typedef struct packed { logic [7:0] st; logic al; } item_t;
  item_t exp_q[$];
  string tag_q[$];
  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  logic       m_busy = 0, m_wel = 0, m_dir = 0, m_lock = 0;
  logic [2:0] m_lvl = 0;

  function automatic bit m_prot(input logic [20:0] a);
    int unsigned n, size;
    if (m_lvl == 3'd0) return 0;
    n = (m_lvl > 3'd5) ? 5 : int'(m_lvl);
    size = 32'h10000 << (n - 1);
    if (m_dir) return (a < size);
    return (a >= 32'h200000 - size);
  endfunction

  task automatic step(input bit wren, wrdi, wrsr, pe, done,
                      input logic [7:0] d, input bit wpn,
                      input logic [20:0] a, input string tag);
    item_t it;
    @(negedge clk);
    cmd_wren = wren; cmd_wrdi = wrdi; cmd_wrsr = wrsr; cmd_pe = pe;
    op_done = done; sr_wdata = d; wp_n = wpn; addr = a;
    it.al = m_wel && !m_busy && !m_prot(a);
    if (m_busy) begin
      if (done) begin m_busy = 0; m_wel = 0; end
    end else if (wren) m_wel = 1;
    else if (wrdi) m_wel = 0;
    else if (wrsr && m_wel) begin
      m_busy = 1;
      if (!(m_lock && !wpn)) begin m_lock = d[7]; m_dir = d[5]; m_lvl = d[4:2]; end
    end else if (pe && m_wel) begin
      if (m_prot(a)) m_wel = 0; else m_busy = 1;
    end
    it.st = {m_lock, 1'b0, m_dir, m_lvl, m_wel, m_busy};
    exp_q.push_back(it);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input logic [20:0] a, input string tag);
    step(0, 0, 0, 0, 0, 8'h00, 1, a, tag);
  endtask

  task automatic set_sr(input logic [7:0] d, input string tag);
    step(1, 0, 0, 0, 0, 8'h00, 1, '0, tag);
    step(0, 0, 1, 0, 0, d, 1, '0, tag);
    step(0, 0, 0, 0, 1, 8'h00, 1, '0, tag);
  endtask

  initial begin : monitor
    logic al_s;
    item_t it;
    string tg;
    forever begin
      @(negedge clk); #1; al_s = pe_allowed;
      @(posedge clk); #1;
      if (exp_q.size() > 0) begin
        it = exp_q.pop_front();
        tg = tag_q.pop_front();
        n_tests++;
        if (status !== it.st || al_s !== it.al) begin
          n_fail++;
          $display("FAIL %s: status=%02h allowed=%0b expected status=%02h allowed=%0b",
                   tg, status, al_s, it.st, it.al);
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : driver
    logic [20:0] bnd;
    string tg;
    #12;
    n_tests++;
    if (status !== 8'h00) begin
      n_fail++;
      $display("FAIL R1: reset status=%02h expected=00", status);
    end
    @(negedge clk); rst_n = 1'b1;

    step(0, 0, 1, 0, 0, 8'hFF, 1, '0, "R4 status write without latch");
    step(1, 0, 0, 0, 0, 8'h00, 1, 21'h1FFFFF, "R3 wren / R1 all unprotected");
    idle(21'h1FFFFF, "R1 top address allowed after reset");
    step(0, 1, 0, 0, 0, 8'h00, 1, '0, "R3 wrdi");
    step(1, 0, 0, 0, 0, 8'h00, 1, '0, "R3 wren again");
    step(0, 0, 1, 0, 0, 8'hFF, 1, '0, "R4 R2 status write FF");
    step(1, 1, 0, 1, 0, 8'h00, 1, '0, "R7 strobes ignored while busy");
    step(0, 0, 1, 0, 0, 8'h00, 1, '0, "R7 status write ignored while busy");
    step(0, 0, 0, 0, 1, 8'h00, 1, '0, "R6 done clears busy and latch");
    step(0, 0, 0, 0, 1, 8'h00, 1, '0, "R6 done ignored when idle");
    step(1, 0, 0, 0, 0, 8'h00, 0, '0, "R5 wren");
    step(0, 0, 1, 0, 0, 8'h00, 0, '0, "R5 locked write keeps fields");
    step(0, 0, 0, 0, 1, 8'h00, 0, '0, "R5 done");
    step(1, 0, 0, 0, 0, 8'h00, 1, '0, "R5 wren pin high");
    step(0, 0, 1, 0, 0, 8'h14, 1, '0, "R5 pin high write applies");
    step(0, 0, 0, 0, 1, 8'h00, 1, '0, "R5 done");

    set_sr(8'h20, "R8 level 0 dir 1");
    step(1, 0, 0, 0, 0, 8'h00, 1, '0, "R8 wren");
    idle(21'h000000, "R8 bottom allowed");
    idle(21'h1FFFFF, "R8 top allowed");
    step(0, 1, 0, 0, 0, 8'h00, 1, '0, "R8 wrdi");

    for (int d = 0; d < 2; d++) begin
      for (int l = 1; l < 8; l++) begin
        int unsigned sz;
        tg = (l > 5) ? "R11" : (d == 1) ? "R10" : "R9";
        set_sr({2'b00, d[0], l[2:0], 2'b00}, tg);
        step(1, 0, 0, 0, 0, 8'h00, 1, '0, tg);
        sz = 32'h10000 << (((l > 5) ? 5 : l) - 1);
        if (d == 0) begin
          bnd = 21'(32'h200000 - sz);
          idle(bnd - 21'd1, {tg, " below region"});
          idle(bnd, {tg, " region start"});
          idle(21'h1FFFFF, {tg, " region end"});
        end else begin
          bnd = 21'(sz);
          idle(21'h000000, {tg, " region start"});
          idle(bnd - 21'd1, {tg, " region end"});
          idle(bnd, {tg, " above region"});
        end
        step(0, 1, 0, 0, 0, 8'h00, 1, '0, tg);
      end
    end

    set_sr(8'h0C, "R12 level 3 top");
    step(1, 0, 0, 0, 0, 8'h00, 1, '0, "R12 wren");
    step(0, 0, 0, 1, 0, 8'h00, 1, 21'h010000, "R12 program unprotected");
    step(0, 0, 0, 0, 1, 8'h00, 1, '0, "R12 done");
    step(1, 0, 0, 0, 0, 8'h00, 1, '0, "R13 wren");
    step(0, 0, 0, 1, 0, 8'h00, 1, 21'h1C0000, "R13 program protected");
    idle(21'h010000, "R13 latch cleared");
    step(0, 0, 0, 1, 0, 8'h00, 1, 21'h010000, "R12 program without latch ignored");

    repeat (4) @(negedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule